// File: doc/BRIEF.md
# Sized-Transfer Status Flag Controller

This block keeps the sticky status flags of a serial peripheral that runs transfers of a programmed number of frames, and it drives one interrupt line. Strobes come in from the frame engine: a frame completed on the bus, a frame pushed into the transmit FIFO, a CRC frame completed, and error detects. The block counts down the remaining frames and raises end-of-transfer when the count runs out. If CRC is on, end-of-transfer waits for the trailing CRC frame. It also raises transmit-filled when every frame of the transfer has been pushed. Error, suspend and transmission-complete flags are tracked beside them.

The block owns the peripheral enable and IO-lock bits, because a mode fault must force both off. While the fault flag is set, software cannot turn the enable back on. Software clears flags through a write-one-to-clear vector. Some flags also clear when the peripheral is re-enabled; others clear only through that vector. When transmit-filled rises, a one-cycle pulse tells the interrupt-enable register to drop the TX-packet and duplex-packet enables.

Top module: `xfer_evt_ctrl`

## Requirements
- R1: `remaining` loads `cfg_size` on every clock while the peripheral is disabled. While enabled, it drops by one on each `frame_done`, and it stays at 0 once it gets there.
- R2: With CRC off, the end-of-transfer flag (`status_flags[0]`) reads 1 after the clock edge that takes the frame with `remaining` == 1. Writing 1 to `clr_w1c[0]` clears it.
- R3: With `cfg_crc_en` = 1, end-of-transfer stays 0 after the last data frame. It reads 1 after the edge that takes `crc_frame_done`.
- R4: The transmit-filled flag (`status_flags[1]`) reads 1 after the edge that takes the `cfg_size`-th `frame_pushed`. `ie_autoclr` is high for exactly that one cycle. The flag survives a re-enable and clears only through `clr_w1c[1]`.
- R5: Underrun (bit 2), overrun (bit 3) and CRC error (bit 4) set on their strobes. Each clears through its `clr_w1c` bit or on a re-enable. Underrun can set only while `cfg_master` = 0.
- R6: Frame-format error (bit 5) and mode fault (bit 6) set on their strobes. They survive a re-enable and clear only through their `clr_w1c` bit.
- R7: `err_modf` forces `periph_en` and `iolock` to 0 after the same edge. While bit 6 is set, a write of 1 to the enable is ignored.
- R8: With `cfg_master` = 1, the suspend flag (bit 7) sets on the first `frame_done` after a `susp_req`. It also sets when `rxfifo_full` arrives with `cfg_auto_susp_rx` = 1. It never sets in slave mode, and it clears only through `clr_w1c[7]`.
- R9: Transmission-complete (bit 8) reads 1 after any edge at which the peripheral was disabled. While enabled with `cfg_size` = 0, it follows `txfifo_empty` AND `bus_idle`. With a nonzero size, it copies the next value of end-of-transfer, including software clears.
- R10: `irq` is a combinational OR of terms. `irq_en[0]` gates end-of-transfer, suspend and transmission-complete together. `irq_en[k]` gates `status_flags[k]` for k = 1 to 6.
- R11: A set strobe in the same cycle as a clear of that flag leaves the flag at 1.
- R12: Re-enabling the peripheral (0 to 1 on `periph_en`) clears end-of-transfer at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 16 | Frames in the transfer (0 means unsized) |
| cfg_crc_en | input | 1 | A CRC frame follows the data frames |
| cfg_master | input | 1 | 1 for master, 0 for slave |
| cfg_auto_susp_rx | input | 1 | Suspend on receive FIFO full |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| iolock_wr | input | 1 | Write strobe for the IO-lock bit |
| iolock_wdata | input | 1 | Value written to the IO-lock bit |
| frame_done | input | 1 | A data frame completed on the bus |
| crc_frame_done | input | 1 | The CRC frame completed on the bus |
| frame_pushed | input | 1 | A frame was pushed into the transmit FIFO |
| err_udr | input | 1 | Underrun detected |
| err_ovr | input | 1 | Overrun detected |
| err_crc | input | 1 | CRC mismatch detected |
| err_tifre | input | 1 | Frame-format error detected |
| err_modf | input | 1 | Mode fault detected |
| susp_req | input | 1 | Software suspend request |
| rxfifo_full | input | 1 | Receive FIFO is full |
| txfifo_empty | input | 1 | Transmit FIFO is empty |
| bus_idle | input | 1 | No activity on the bus |
| clr_w1c | input | 8 | Write-one-to-clear strobes for flag bits 0 to 7 |
| irq_en | input | 7 | Interrupt enables (bit 0 covers flags 0, 7 and 8) |
| status_flags | output | 9 | Flag vector, bits 0 to 8 as in R2 to R9 |
| remaining | output | 16 | Frames left in the sized transfer |
| periph_en | output | 1 | Peripheral enable bit |
| iolock | output | 1 | IO-lock bit |
| ie_autoclr | output | 1 | Pulse that drops the TX-packet and duplex-packet interrupt enables |
| irq | output | 1 | Interrupt line |

## Verification
Every flag, the counter, the enable, the IO-lock bit and `ie_autoclr` are registered. A strobe held over one rising edge therefore shows up on the outputs right after that edge. The bench samples a quarter period after that edge and checks against that single edge. End-of-transfer with CRC and transmission-complete after a disable each need one extra edge, and the bench ticks once more before sampling them. `irq` is combinational from the flags and `irq_en`, so the bench checks it a short delay after changing `irq_en`, with no clock edge in between.

// File: rtl/xfer_evt_pkg.sv
package xfer_evt_pkg;

  localparam int FL_EOT   = 0;
  localparam int FL_TXTF  = 1;
  localparam int FL_UDR   = 2;
  localparam int FL_OVR   = 3;
  localparam int FL_CRCE  = 4;
  localparam int FL_TIFRE = 5;
  localparam int FL_MODF  = 6;
  localparam int FL_SUSP  = 7;
  localparam int FL_TXC   = 8;

  localparam int NUM_FLAGS  = 9;
  localparam int NUM_STICKY = 8;
  localparam int NUM_IE     = 7;

  // flags that also drop when the peripheral is re-enabled
  function automatic bit f_clr_on_reen(input int idx);
    return (idx == FL_EOT) || (idx == FL_UDR) || (idx == FL_OVR) || (idx == FL_CRCE);
  endfunction

  // sticky flag update: a set beats a clear in the same cycle
  function automatic logic f_sticky_next(input logic cur, input logic set_ev, input logic clr_ev);
    if (set_ev)      return 1'b1;
    else if (clr_ev) return 1'b0;
    else             return cur;
  endfunction

  // count-down update that saturates at zero
  function automatic logic [15:0] f_count_next(input logic [15:0] cur, input logic load,
                                               input logic [15:0] load_val, input logic step);
    if (load)                     return load_val;
    else if (step && cur != '0)   return cur - 16'd1;
    else                          return cur;
  endfunction

  // interrupt combine: enable 0 covers the end-of-transfer group
  function automatic logic f_irq(input logic [NUM_FLAGS-1:0] fl, input logic [NUM_IE-1:0] ie);
    logic acc;
    acc = (fl[FL_EOT] | fl[FL_SUSP] | fl[FL_TXC]) & ie[0];
    for (int k = 1; k < NUM_IE; k++) acc = acc | (fl[k] & ie[k]);
    return acc;
  endfunction

endpackage

// File: rtl/xfer_sticky_flag.sv
module xfer_sticky_flag #(
  parameter bit CLR_ON_REEN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic w1c,
  input  logic reen,
  output logic q
);
  import xfer_evt_pkg::*;

  logic clr_ev;
  assign clr_ev = w1c | (CLR_ON_REEN & reen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= f_sticky_next(q, set_ev, clr_ev);
  end
endmodule

// File: rtl/xfer_down_counter.sv
module xfer_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  import xfer_evt_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nxt;

  generate
    if (CNT_W == 16) begin : g_pkg_math
      assign nxt = f_count_next(count, load, load_val, step);
    end else begin : g_local_math
      assign nxt = load ? load_val : ((step && count != '0) ? count - ONE : count);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end
endmodule

// File: rtl/xfer_enable_guard.sv
module xfer_enable_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic iolock_wr,
  input  logic iolock_wdata,
  input  logic modf_set_ev,
  input  logic modf_q,
  output logic en_q,
  output logic iolock_q,
  output logic en_rise_ev
);
  logic en_next;
  logic lock_next;

  always_comb begin
    en_next = en_q;
    if (modf_set_ev)  en_next = 1'b0;
    else if (en_wr)   en_next = en_wdata & ~modf_q;
  end

  always_comb begin
    lock_next = iolock_q;
    if (modf_set_ev)    lock_next = 1'b0;
    else if (iolock_wr) lock_next = iolock_wdata;
  end

  assign en_rise_ev = ~en_q & en_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      iolock_q <= 1'b0;
    end else begin
      en_q     <= en_next;
      iolock_q <= lock_next;
    end
  end
endmodule

// File: rtl/xfer_evt_ctrl.sv
module xfer_evt_ctrl
  import xfer_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cfg_size,
  input  logic                  cfg_crc_en,
  input  logic                  cfg_master,
  input  logic                  cfg_auto_susp_rx,
  input  logic                  en_wr,
  input  logic                  en_wdata,
  input  logic                  iolock_wr,
  input  logic                  iolock_wdata,
  input  logic                  frame_done,
  input  logic                  crc_frame_done,
  input  logic                  frame_pushed,
  input  logic                  err_udr,
  input  logic                  err_ovr,
  input  logic                  err_crc,
  input  logic                  err_tifre,
  input  logic                  err_modf,
  input  logic                  susp_req,
  input  logic                  rxfifo_full,
  input  logic                  txfifo_empty,
  input  logic                  bus_idle,
  input  logic [NUM_STICKY-1:0] clr_w1c,
  input  logic [NUM_IE-1:0]     irq_en,
  output logic [NUM_FLAGS-1:0]  status_flags,
  output logic [CNT_W-1:0]      remaining,
  output logic                  periph_en,
  output logic                  iolock,
  output logic                  ie_autoclr,
  output logic                  irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // named internal events, visible to the checker
  logic                  en_rise_ev;
  logic                  rx_last_ev;
  logic                  eot_set_ev;
  logic                  txtf_set_ev;
  logic                  susp_set_ev;
  logic                  modf_set_ev;
  logic [NUM_STICKY-1:0] flag_set;
  logic [NUM_STICKY-1:0] flag_q;
  logic [CNT_W-1:0]      tx_left;
  logic                  crc_wait;
  logic                  susp_pend;
  logic                  eot_next;
  logic                  txc_q;

  xfer_enable_guard u_en (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_wr        (en_wr),
    .en_wdata     (en_wdata),
    .iolock_wr    (iolock_wr),
    .iolock_wdata (iolock_wdata),
    .modf_set_ev  (modf_set_ev),
    .modf_q       (flag_q[FL_MODF]),
    .en_q         (periph_en),
    .iolock_q     (iolock),
    .en_rise_ev   (en_rise_ev)
  );

  xfer_down_counter #(.CNT_W(CNT_W)) u_rx_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (~periph_en),
    .load_val (cfg_size),
    .step     (frame_done),
    .count    (remaining)
  );

  xfer_down_counter #(.CNT_W(CNT_W)) u_tx_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (~periph_en),
    .load_val (cfg_size),
    .step     (frame_pushed),
    .count    (tx_left)
  );

  assign rx_last_ev  = periph_en & frame_done & (remaining == ONE);
  assign eot_set_ev  = periph_en & ((rx_last_ev & ~cfg_crc_en) | (crc_wait & crc_frame_done));
  assign txtf_set_ev = periph_en & frame_pushed & (tx_left == ONE);
  assign susp_set_ev = cfg_master & ((susp_pend & frame_done) | (cfg_auto_susp_rx & rxfifo_full));
  assign modf_set_ev = err_modf;

  always_comb begin
    flag_set           = '0;
    flag_set[FL_EOT]   = eot_set_ev;
    flag_set[FL_TXTF]  = txtf_set_ev;
    flag_set[FL_UDR]   = err_udr & ~cfg_master;
    flag_set[FL_OVR]   = err_ovr;
    flag_set[FL_CRCE]  = err_crc;
    flag_set[FL_TIFRE] = err_tifre;
    flag_set[FL_MODF]  = modf_set_ev;
    flag_set[FL_SUSP]  = susp_set_ev;
  end

  generate
    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_flag
      xfer_sticky_flag #(.CLR_ON_REEN(f_clr_on_reen(g))) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (flag_set[g]),
        .w1c    (clr_w1c[g]),
        .reen   (en_rise_ev),
        .q      (flag_q[g])
      );
    end
  endgenerate

  // CRC tail tracking and suspend request latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_wait  <= 1'b0;
      susp_pend <= 1'b0;
    end else begin
      if (!periph_en)                    crc_wait <= 1'b0;
      else if (rx_last_ev && cfg_crc_en) crc_wait <= 1'b1;
      else if (crc_frame_done)           crc_wait <= 1'b0;

      if (susp_set_ev)                   susp_pend <= 1'b0;
      else if (susp_req && cfg_master)   susp_pend <= 1'b1;
    end
  end

  // transmission complete: forced while off, level when unsized, else copies EOT
  assign eot_next = f_sticky_next(flag_q[FL_EOT], eot_set_ev,
                                  clr_w1c[FL_EOT] | en_rise_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               txc_q <= 1'b1;
    else if (!periph_en)      txc_q <= 1'b1;
    else if (cfg_size == '0)  txc_q <= txfifo_empty & bus_idle;
    else                      txc_q <= eot_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_autoclr <= 1'b0;
    else        ie_autoclr <= txtf_set_ev;
  end

  assign status_flags = {txc_q, flag_q};
  assign irq          = f_irq(status_flags, irq_en);

endmodule

// File: rtl/xfer_evt_ctrl_chk.sv
module xfer_evt_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic             frame_done,
  input logic             err_modf,
  input logic             en_wr,
  input logic             periph_en,
  input logic             iolock,
  input logic             ie_autoclr,
  input logic [8:0]       status_flags,
  input logic [CNT_W-1:0] remaining,
  input logic [7:0]       flag_set,
  input logic             txtf_set_ev
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && frame_done && remaining != '0 && !en_wr && !err_modf)
      |=> remaining == $past(remaining) - ONE);

  p_eot_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_flags[0]) |-> remaining == '0);

  p_txtf_autoclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txtf_set_ev |=> (ie_autoclr && status_flags[1]));

  p_udr_slave_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !status_flags[2]) |=> !status_flags[2]);

  p_modf_drops_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_modf |=> (!periph_en && !iolock));

  p_modf_blocks_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[6] |-> !periph_en);

  p_txc_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> status_flags[8]);

  p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[3] |=> status_flags[3]);
endmodule

bind xfer_evt_ctrl xfer_evt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_master   (cfg_master),
  .frame_done   (frame_done),
  .err_modf     (err_modf),
  .en_wr        (en_wr),
  .periph_en    (periph_en),
  .iolock       (iolock),
  .ie_autoclr   (ie_autoclr),
  .status_flags (status_flags),
  .remaining    (remaining),
  .flag_set     (flag_set),
  .txtf_set_ev  (txtf_set_ev)
);

// File: tb/xfer_evt_ctrl_tb_top.sv
module xfer_evt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cfg_size = '0;
  logic cfg_crc_en = 0, cfg_master = 0, cfg_auto_susp_rx = 0;
  logic en_wr = 0, en_wdata = 0, iolock_wr = 0, iolock_wdata = 0;
  logic frame_done = 0, crc_frame_done = 0, frame_pushed = 0;
  logic err_udr = 0, err_ovr = 0, err_crc = 0, err_tifre = 0, err_modf = 0;
  logic susp_req = 0, rxfifo_full = 0, txfifo_empty = 0, bus_idle = 0;
  logic [7:0] clr_w1c = '0;
  logic [6:0] irq_en = '0;
  logic [8:0] status_flags;
  logic [W-1:0] remaining;
  logic periph_en, iolock, ie_autoclr, irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_evt_ctrl #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_crc_en(cfg_crc_en),
    .cfg_master(cfg_master), .cfg_auto_susp_rx(cfg_auto_susp_rx),
    .en_wr(en_wr), .en_wdata(en_wdata), .iolock_wr(iolock_wr), .iolock_wdata(iolock_wdata),
    .frame_done(frame_done), .crc_frame_done(crc_frame_done), .frame_pushed(frame_pushed),
    .err_udr(err_udr), .err_ovr(err_ovr), .err_crc(err_crc), .err_tifre(err_tifre),
    .err_modf(err_modf), .susp_req(susp_req), .rxfifo_full(rxfifo_full),
    .txfifo_empty(txfifo_empty), .bus_idle(bus_idle), .clr_w1c(clr_w1c), .irq_en(irq_en),
    .status_flags(status_flags), .remaining(remaining), .periph_en(periph_en),
    .iolock(iolock), .ie_autoclr(ie_autoclr), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic set_en(input logic v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0; en_wdata = 0;
  endtask

  task automatic reenable();
    set_en(1'b0); set_en(1'b1);
  endtask

  task automatic w1c(input int b);
    clr_w1c = '0; clr_w1c[b] = 1'b1; tick(); clr_w1c = '0;
  endtask

  task automatic pulse_err(input int idx);
    case (idx)
      2: err_udr = 1;
      3: err_ovr = 1;
      4: err_crc = 1;
      5: err_tifre = 1;
      default: err_modf = 1;
    endcase
    tick();
    err_udr = 0; err_ovr = 0; err_crc = 0; err_tifre = 0; err_modf = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1;
    tick();
    // reset state: only transmission-complete set (R9), counter 0 (R1)
    chk("R9 reset flags", int'(status_flags), 9'h100);
    chk("R1 reset count", int'(remaining), 0);
    chk("R7 reset enable", int'(periph_en), 0);
    chk("R10 reset irq", int'(irq), 0);

    // end-of-transfer sweep over size and CRC mode
    cfg_master = 1;
    for (int sz = 1; sz <= 4; sz++) begin
      for (int crc = 0; crc < 2; crc++) begin
        cfg_size = W'(sz); cfg_crc_en = crc[0];
        set_en(1'b0);
        tick();
        chk("R1 load while off", int'(remaining), sz);
        set_en(1'b1);
        chk("R12 eot cleared on re-enable", int'(status_flags[0]), 0);
        chk("R9 txc after enabling edge", int'(status_flags[8]), 1);
        for (int f = 0; f < sz; f++) begin
          frame_done = 1; tick(); frame_done = 0;
          chk("R1 decrement", int'(remaining), sz - 1 - f);
          chk(crc ? "R3 eot held for crc" : "R2 eot on last frame",
              int'(status_flags[0]), (f == sz - 1 && crc == 0) ? 1 : 0);
          chk("R9 txc mirrors eot", int'(status_flags[8]), (f == sz - 1 && crc == 0) ? 1 : 0);
        end
        if (crc != 0) begin
          tick();
          chk("R3 eot waits", int'(status_flags[0]), 0);
          crc_frame_done = 1; tick(); crc_frame_done = 0;
          chk("R3 eot after crc frame", int'(status_flags[0]), 1);
        end
        frame_done = 1; tick(); frame_done = 0;
        chk("R1 saturate at zero", int'(remaining), 0);
        irq_en = 7'b0000001; #1;
        chk("R10 irq from eot", int'(irq), 1);
        irq_en = '0; #1;
        chk("R10 irq masked", int'(irq), 0);
        if (crc == 0) begin
          w1c(0);
          chk("R2 eot w1c", int'(status_flags[0]), 0);
          chk("R9 txc follows eot clear", int'(status_flags[8]), 0);
        end
      end
    end

    // transmit-filled sweep
    cfg_crc_en = 0;
    for (int sz = 1; sz <= 4; sz++) begin
      cfg_size = W'(sz);
      set_en(1'b0); tick(); set_en(1'b1);
      for (int f = 0; f < sz; f++) begin
        frame_pushed = 1; tick(); frame_pushed = 0;
        chk("R4 txtf set point", int'(status_flags[1]), (f == sz - 1) ? 1 : 0);
        chk("R4 autoclear pulse", int'(ie_autoclr), (f == sz - 1) ? 1 : 0);
      end
      tick();
      chk("R4 pulse one cycle", int'(ie_autoclr), 0);
      reenable();
      chk("R4 txtf survives re-enable", int'(status_flags[1]), 1);
      w1c(1);
      chk("R4 txtf w1c", int'(status_flags[1]), 0);
    end

    // error flags
    cfg_master = 0; cfg_size = '0;
    for (int idx = 2; idx <= 6; idx++) begin
      string rq;
      rq = (idx < 5) ? "R5" : "R6";
      iolock_wr = 1; iolock_wdata = 1; tick(); iolock_wr = 0; iolock_wdata = 0;
      reenable();
      pulse_err(idx);
      chk({rq, " flag set"}, int'(status_flags[idx]), 1);
      if (idx == 6) begin
        chk("R7 enable forced off", int'(periph_en), 0);
        chk("R7 iolock forced off", int'(iolock), 0);
      end
      reenable();
      chk({rq, " re-enable effect"}, int'(status_flags[idx]), (idx < 5) ? 0 : 1);
      if (idx == 6) chk("R7 enable write ignored", int'(periph_en), 0);
      else          pulse_err(idx);
      w1c(idx);
      chk({rq, " w1c"}, int'(status_flags[idx]), 0);
      if (idx == 6) begin
        set_en(1'b1);
        chk("R7 enable after clear", int'(periph_en), 1);
      end
    end

    // underrun ignored in master mode
    cfg_master = 1;
    pulse_err(2);
    chk("R5 udr ignored in master", int'(status_flags[2]), 0);

    // set beats clear
    err_ovr = 1; clr_w1c[3] = 1; tick(); err_ovr = 0; clr_w1c = '0;
    chk("R11 set wins over clear", int'(status_flags[3]), 1);
    w1c(3);
    chk("R5 ovr w1c", int'(status_flags[3]), 0);

    // suspend
    reenable();
    susp_req = 1; tick(); susp_req = 0;
    chk("R8 no suspend before frame", int'(status_flags[7]), 0);
    frame_done = 1; tick(); frame_done = 0;
    chk("R8 suspend after frame", int'(status_flags[7]), 1);
    reenable();
    chk("R8 survives re-enable", int'(status_flags[7]), 1);
    w1c(7);
    chk("R8 w1c", int'(status_flags[7]), 0);
    cfg_auto_susp_rx = 1; rxfifo_full = 1; tick(); rxfifo_full = 0;
    chk("R8 auto suspend on full", int'(status_flags[7]), 1);
    w1c(7);
    chk("R8 w1c auto", int'(status_flags[7]), 0);
    cfg_master = 0; rxfifo_full = 1; tick(); rxfifo_full = 0;
    chk("R8 slave never suspends", int'(status_flags[7]), 0);
    cfg_auto_susp_rx = 0;

    // transmission complete, unsized transfer
    cfg_size = '0; txfifo_empty = 0; bus_idle = 0;
    set_en(1'b0); set_en(1'b1);
    chk("R9 txc on enabling edge", int'(status_flags[8]), 1);
    tick();
    chk("R9 txc busy", int'(status_flags[8]), 0);
    txfifo_empty = 1; bus_idle = 1; tick();
    chk("R9 txc empty and idle", int'(status_flags[8]), 1);
    bus_idle = 0; tick();
    chk("R9 txc bus active", int'(status_flags[8]), 0);
    set_en(1'b0); tick();
    chk("R9 txc while off", int'(status_flags[8]), 1);

    // interrupt combine
    irq_en = '0; #1;
    chk("R10 all masked", int'(irq), 0);
    irq_en = 7'b0000001; #1;
    chk("R10 txc via group enable", int'(irq), 1);
    irq_en = '0;
    pulse_err(5);
    irq_en = 7'b0100000; #1;
    chk("R10 tifre enable", int'(irq), 1);
    irq_en = 7'b1011110; #1;
    chk("R10 other enables", int'(irq), 0);
    irq_en = '0;
    w1c(5);

    finish_run();
  end
endmodule